// File: doc/BRIEF.md
# Reduced 4x4 Inverse DCT

This block rebuilds a quarter-resolution image tile from one 8x8 block of quantized transform coefficients. The caller streams 64 coefficient and quantizer pairs in row-major order over a valid/ready handshake. The block multiplies each coefficient by its quantizer and runs a fixed-point column pass over the eight columns. It then runs a row pass over the four intermediate rows, and emits sixteen unsigned 8-bit pixels in raster order.

Both passes use one shared 4-point even/odd butterfly with ten constants scaled by 2^13. Row 4 of the input and column 4 of the intermediate result are never read. When the raw AC coefficients in rows 1, 2, 3, 5, 6 and 7 are all zero for the columns 0-3, or for the columns 4-7, the column pass takes a DC-only shortcut for those columns. The shortcut gives the same numbers as the full arithmetic.

Top module: `idct4_reduce`

## Requirements
- R1: After reset, out_valid and out_last are 0 and in_ready is 1.
- R2: A pair is accepted on each clock edge where in_valid and in_ready are both 1. The 64 accepted pairs are ordered row-major: index = 8*row + column. After the 64th pair, in_ready stays 0 until the output burst has ended.
- R3: Each dequantized value is the low 16 bits, taken as signed, of the product in_coef*in_quant. A product above the 16-bit range therefore wraps.
- R4: The column pass computes x0<<14 and the terms 15137*x2 - 6270*x6, 8697*x1 - 17799*x3 + 11893*x5 - 1730*x7 and 20995*x1 + 7373*x3 - 4926*x5 - 4176*x7, all in 32-bit wrapping arithmetic. It forms out0 = e10+p2, out1 = e12+p0, out2 = e12-p0 and out3 = e10-p2, with e10/e12 = x0<<14 plus/minus the even term. Each output is rounded, shifted right by 12 and kept as 16 bits.
- R5: Coefficient row 4, and intermediate column 4, have no effect on any output pixel.
- R6: When a column half has all-zero raw AC terms, its intermediate values equal the dequantized DC shifted left by 2. The pixels equal those of the full computation.
- R7: The row pass applies the same butterfly to intermediate columns 0, 1, 2, 3, 5, 6 and 7. Each result is rounded and shifted right by 19, offset by 128 and clamped to 0..255. An all-zero block gives 128 everywhere.
- R8: The 16 pixels leave on 16 consecutive cycles with out_valid high, in the order row 0 column 0 first, columns before rows. out_last is high only with the 16th pixel.
- R9: On the cycle after out_last, out_valid is 0 and in_ready is 1 again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Coefficient pair present |
| in_ready | output | 1 | Block accepts a pair |
| in_coef | input | 16 | Signed quantized coefficient |
| in_quant | input | 16 | Signed quantizer for that coefficient |
| out_valid | output | 1 | Pixel present |
| out_pix | output | 8 | Unsigned output pixel |
| out_last | output | 1 | Final pixel of the block |

## Verification
The column pass can mix two functions inside one block: the DC-only shortcut for one column half and the full butterfly for the other. Each intermediate row then holds values from both. Directed blocks with AC energy in only the left half, or only the right half, provoke this mix. Random blocks with sparse AC terms provoke it as well. Every pixel is judged against a bench model that always takes the full arithmetic path, so any mismatch between the shortcut and the full path shows up as a pixel error.

// File: rtl/idct4_reduce.sv
module idct4_reduce (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic signed [15:0] in_coef,
  input  logic signed [15:0] in_quant,
  output logic               out_valid,
  output logic [7:0]         out_pix,
  output logic               out_last
);

  typedef enum logic [1:0] {LOAD, COLS, ROWS, EMIT} st_t;

  st_t                st;
  logic [5:0]         cnt;
  logic [1:0]         nz;
  logic signed [15:0] deq  [64];
  logic signed [15:0] ws   [32];
  logic [7:0]         pbuf [16];
  logic signed [15:0] bx   [8];
  logic signed [31:0] bo   [4];
  logic signed [31:0] prod;
  logic [127:0]       bres;
  logic               ac_hit;

  function automatic logic [127:0] bfly(input logic signed [15:0] x0, x1, x2, x3, x5, x6, x7);
    logic signed [31:0] t0, t2, e10, e12, p0, p2;
    t0  = 32'(x0) <<< 14;
    t2  = 32'(x2) * 32'sd15137 - 32'(x6) * 32'sd6270;
    e10 = t0 + t2;
    e12 = t0 - t2;
    p0  = 32'(x1) * 32'sd8697 - 32'(x3) * 32'sd17799 + 32'(x5) * 32'sd11893 - 32'(x7) * 32'sd1730;
    p2  = 32'(x1) * 32'sd20995 + 32'(x3) * 32'sd7373 - 32'(x5) * 32'sd4926 - 32'(x7) * 32'sd4176;
    return {e10 + p2, e12 + p0, e12 - p0, e10 - p2};
  endfunction

  function automatic logic signed [15:0] rnd12(input logic signed [31:0] s);
    logic signed [32:0] w;
    w = (33'(s) + 33'sd2048) >>> 12;
    return w[15:0];
  endfunction

  function automatic logic [7:0] pix(input logic signed [31:0] s);
    logic signed [32:0] v;
    v = ((33'(s) + 33'sd262144) >>> 19) + 33'sd128;
    if (v < 33'sd0) return 8'd0;
    else if (v > 33'sd255) return 8'd255;
    else return v[7:0];
  endfunction

  assign in_ready  = (st == LOAD);
  assign out_valid = (st == EMIT);
  assign out_last  = out_valid && (cnt == 6'd15);
  assign out_pix   = pbuf[cnt[3:0]];
  assign prod      = in_coef * in_quant;
  assign ac_hit    = (in_coef != 16'sd0) && (cnt[5:3] != 3'd0) && (cnt[5:3] != 3'd4);

  always_comb begin
    for (int k = 0; k < 8; k++)
      bx[k] = (st == ROWS) ? ws[{cnt[1:0], 3'(k)}] : deq[{3'(k), cnt[2:0]}];
  end

  assign bres = bfly(bx[0], bx[1], bx[2], bx[3], bx[5], bx[6], bx[7]);

  always_comb begin
    for (int i = 0; i < 4; i++)
      bo[i] = bres[127 - 32*i -: 32];
  end

  always_ff @(posedge clk) begin
    if (st == LOAD && in_valid)
      deq[cnt] <= prod[15:0];
    if (st == COLS)
      for (int i = 0; i < 4; i++)
        ws[{2'(i), cnt[2:0]}] <= nz[cnt[2]] ? rnd12(bo[i]) : (deq[{3'd0, cnt[2:0]}] <<< 2);
    if (st == ROWS)
      for (int i = 0; i < 4; i++)
        pbuf[{cnt[1:0], 2'(i)}] <= pix(bo[i]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= LOAD;
      cnt <= '0;
      nz  <= '0;
    end else begin
      case (st)
        LOAD: if (in_valid) begin
          if (cnt == 6'd0) nz <= '0;
          else if (ac_hit) nz[cnt[2]] <= 1'b1;
          cnt <= cnt + 6'd1;
          if (cnt == 6'd63) st <= COLS;
        end
        COLS: begin
          cnt <= (cnt == 6'd7) ? 6'd0 : cnt + 6'd1;
          if (cnt == 6'd7) st <= ROWS;
        end
        ROWS: begin
          cnt <= (cnt == 6'd3) ? 6'd0 : cnt + 6'd1;
          if (cnt == 6'd3) st <= EMIT;
        end
        default: begin
          cnt <= (cnt == 6'd15) ? 6'd0 : cnt + 6'd1;
          if (cnt == 6'd15) st <= LOAD;
        end
      endcase
    end
  end

  // R8
  last_with_valid_chk: assert property (@(posedge clk) disable iff (!rst_n) out_last |-> out_valid);
  // R8
  burst_unbroken_chk: assert property (@(posedge clk) disable iff (!rst_n) (out_valid && !out_last) |=> out_valid);
  // R9
  reopen_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n) out_last |=> (in_ready && !out_valid));
  // R2
  stop_after_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && cnt == 6'd63) |=> !in_ready);
  // R2
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n) !(in_ready && out_valid));

endmodule

// File: tb/idct4_reduce_tb_top.sv
module idct4_reduce_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic signed [15:0] in_coef = '0, in_quant = '0;
  logic in_ready, out_valid, out_last;
  logic [7:0] out_pix;

  always #10 clk = ~clk;

  idct4_reduce dut_i (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_coef(in_coef), .in_quant(in_quant), .out_valid(out_valid), .out_pix(out_pix),
    .out_last(out_last));

  int n_cmp = 0, n_bad = 0;
  int coef[64], quant[64];
  int got[16];
  int got_n, last_at, first_cyc, last_cyc, cyc = 0;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) if (rst_n && out_valid) begin
    if (got_n < 16) got[got_n] = out_pix;
    if (got_n == 0) first_cyc = cyc;
    last_cyc = cyc;
    if (out_last) last_at = got_n;
    got_n++;
  end

  task automatic chk(string tag, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic void bf(input int x0, x1, x2, x3, x5, x6, x7, output int o[4]);
    int t0, t2, e10, e12, p0, p2;
    t0 = x0 * 16384;
    t2 = x2 * 15137 - x6 * 6270;
    e10 = t0 + t2; e12 = t0 - t2;
    p0 = x1 * 8697 - x3 * 17799 + x5 * 11893 - x7 * 1730;
    p2 = x1 * 20995 + x3 * 7373 - x5 * 4926 - x7 * 4176;
    o[0] = e10 + p2; o[1] = e12 + p0; o[2] = e12 - p0; o[3] = e10 - p2;
  endfunction

  function automatic int r12(int s);
    longint w = (longint'(s) + 2048) >>> 12;
    return int'(shortint'(w));
  endfunction

  function automatic int px(int s);
    longint v = ((longint'(s) + 262144) >>> 19) + 128;
    return (v < 0) ? 0 : (v > 255) ? 255 : int'(v);
  endfunction

  function automatic void model(output int e[16]);
    int d[64], w[4][8], o[4];
    for (int i = 0; i < 64; i++) d[i] = int'(shortint'(coef[i] * quant[i]));
    for (int c = 0; c < 8; c++) begin
      bf(d[c], d[8+c], d[16+c], d[24+c], d[40+c], d[48+c], d[56+c], o);
      for (int r = 0; r < 4; r++) w[r][c] = r12(o[r]);
    end
    for (int r = 0; r < 4; r++) begin
      bf(w[r][0], w[r][1], w[r][2], w[r][3], w[r][5], w[r][6], w[r][7], o);
      for (int c = 0; c < 4; c++) e[r*4+c] = px(o[c]);
    end
  endfunction

  task automatic run_block(string tag, bit gaps);
    int e[16];
    bit acc;
    model(e);
    got_n = 0; last_at = -1;
    for (int i = 0; i < 64; i++) begin
      if (gaps && ($urandom % 4 == 0)) begin
        @(negedge clk); in_valid = 1'b0;
      end
      acc = 1'b0;
      while (!acc) begin
        @(negedge clk);
        in_valid = 1'b1; in_coef = 16'(coef[i]); in_quant = 16'(quant[i]);
        acc = in_ready;
        @(posedge clk);
      end
    end
    @(negedge clk); in_valid = 1'b0;
    chk({tag, " R2 ready low after 64"}, in_ready, 0);
    for (int t = 0; t < 100; t++) begin
      #1;
      if (got_n >= 16) break;
      @(negedge clk);
    end
    for (int k = 0; k < 16; k++) chk($sformatf("%s R7 pixel %0d", tag, k), got[k], e[k]);
    chk({tag, " R8 last position"}, last_at, 15);
    chk({tag, " R8 consecutive"}, last_cyc - first_cyc, 15);
    @(negedge clk);
    chk({tag, " R9 ready again"}, in_ready, 1);
    chk({tag, " R9 valid low"}, out_valid, 0);
    chk({tag, " R8 count"}, got_n, 16);
  endtask

  task automatic clear(int q);
    for (int i = 0; i < 64; i++) begin coef[i] = 0; quant[i] = q; end
  endtask

  function automatic int rv(int m);
    return int'($urandom_range(2*m, 0)) - m;
  endfunction

  initial begin
    #(20*150000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd24681));
    repeat (3) @(negedge clk);
    chk("R1 out_valid at reset", out_valid, 0);
    chk("R1 out_last at reset", out_last, 0);
    chk("R1 in_ready at reset", in_ready, 1);
    rst_n = 1'b1;
    @(negedge clk);

    clear(5); run_block("zero R6", 0);
    clear(10); coef[0] = 500; run_block("dc high clamp R7", 0);
    clear(10); coef[0] = -500; run_block("dc low clamp R7", 0);
    clear(3); coef[0] = 40; run_block("dc mid R6", 1);

    clear(4); coef[0] = 20;
    for (int r = 1; r < 8; r++) for (int c = 0; c < 4; c++) coef[r*8+c] = rv(30);
    run_block("left half only R6", 1);

    clear(4); coef[0] = -15;
    for (int r = 1; r < 8; r++) for (int c = 4; c < 8; c++) coef[r*8+c] = rv(30);
    run_block("right half only R6", 1);

    clear(6); coef[0] = 12;
    for (int c = 0; c < 8; c++) coef[32+c] = rv(200);
    for (int r = 0; r < 8; r++) coef[r*8+4] = rv(200);
    coef[0] = 12;
    run_block("row4 col4 ignored R5", 0);

    clear(1); coef[0] = 8; coef[8] = 300; quant[8] = 300; coef[17] = -250; quant[17] = 280;
    run_block("dequant wrap R3", 0);

    for (int b = 0; b < 20; b++) begin
      for (int i = 0; i < 64; i++) begin
        quant[i] = int'($urandom_range(12, 1));
        coef[i] = ($urandom % 3 == 0) ? rv(40) : 0;
      end
      coef[0] = rv(120);
      run_block($sformatf("random %0d R4", b), 1);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule